// File: doc/BRIEF.md
# Polymorphic Element-Width Load Sequencer

This block steps through a unit-strided vector load one element at a time. A start pulse captures a base address, an immediate offset, a vector length, a source element size and a destination element size, a data-endian mode bit, a byte-reverse flag and a destination register number. For each element the block issues one memory read of the source size. It may reverse the bytes of the returned value, truncates or zero-extends the result to the destination size, and writes it with byte enables into a 64-bit register file.

The register file uses little-endian numbering at both levels. Elements fill each 64-bit register from the least significant end, and byte 0 of an element is its least significant byte. A big-endian load reverses bytes before truncation, so a narrow destination keeps the bytes at the high end of each memory read.

Top module: `elw_load_seq`

## Requirements
- R1: Element j with a destination size of dw bytes is written to register rd + floor(j*dw/8) at byte offset (j*dw) mod 8. Only bits [offset, offset+dw) of `rf_be` are set.
- R2: Within a written element, its least significant byte sits at the lowest enabled byte lane, and later bytes occupy increasing lanes.
- R3: The read address for element i is base + imm + i*sw, where sw is the source size in bytes.
- R4: Bytes are reversed exactly when `rev_flag` XNOR `le_mode` is 1. A normal load in little-endian mode keeps memory order, and a normal load in big-endian mode reverses it.
- R5: The reversal covers all sw bytes of the read and happens before truncation. With an 8-byte source, a 4-byte destination and big-endian mode, element 0 gets bytes M7,M6,M5,M4 in order from least significant upwards.
- R6: After the optional reversal, the value keeps its dw least significant bytes. When dw > sw, the bytes above sw are zero.
- R7: A start with VL=0 raises `done` on the following cycle and issues no memory request.
- R8: At most one read is outstanding. The next request goes out only after the response for the current one has arrived.
- R9: Each response produces exactly one register write on the next cycle. `done` pulses for one cycle together with the write of the last element, after exactly VL writes.
- R10: The size codes 0,1,2,3 stand for 1,2,4,8 bytes. `mem_req_size` carries the source code.
- R11: In `mem_rsp_data`, byte k (bits 8k+7..8k) holds memory byte address+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load sequence (accepted when idle) |
| base_addr | input | 32 | Base address |
| imm_off | input | 32 | Immediate offset added to each address |
| vec_len | input | 7 | Number of elements (VL) |
| src_code | input | 2 | Source element size code |
| dst_code | input | 2 | Destination element size code |
| le_mode | input | 1 | 1 = little-endian data mode |
| rev_flag | input | 1 | 1 = byte-reversed load variant |
| dest_reg | input | 5 | First destination register |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req_valid | output | 1 | Read request strobe |
| mem_req_addr | output | 32 | Read address |
| mem_req_size | output | 2 | Read size code |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, byte k = address+k |
| rf_we | output | 1 | Register file write strobe |
| rf_addr | output | 5 | Register number |
| rf_wdata | output | 64 | Write data, already shifted into its lanes |
| rf_be | output | 8 | Per-byte write enables |

## Verification
The assertions assume that `mem_rsp_valid` is only raised while a read is outstanding, for one cycle per request, and that `start` is only pulsed while the block is idle. The bench memory model answers each request exactly once, with a latency of one to three cycles, and pulses `start` only after the previous `done`. The sweep covers every source and destination size, all four combinations of the endian and reverse bits, and several vector lengths including zero and lengths that spill over into further registers.

// File: rtl/elw_pkg.sv
package elw_pkg;
  typedef enum logic {S_IDLE = 1'b0, S_WAIT = 1'b1} seq_state_t;

  function automatic int size_bytes(input logic [1:0] code);
    return 1 << code;
  endfunction
endpackage

// File: rtl/elw_byte_order.sv
module elw_byte_order #(
  parameter int NB = 8,
  parameter int CW = 2
) (
  input  logic [8*NB-1:0] raw,
  input  logic [CW-1:0]   size_code,
  input  logic            swap_en,
  output logic [8*NB-1:0] ordered
);
  always_comb begin
    ordered = '0;
    for (int k = 0; k < NB; k++) begin
      if (k < (1 << size_code)) begin
        if (swap_en)
          ordered[8*k +: 8] = raw[8*((1 << size_code) - 1 - k) +: 8];
        else
          ordered[8*k +: 8] = raw[8*k +: 8];
      end
    end
  end
endmodule

// File: rtl/elw_truncate.sv
module elw_truncate #(
  parameter int NB = 8,
  parameter int CW = 2
) (
  input  logic [8*NB-1:0] din,
  input  logic [CW-1:0]   size_code,
  output logic [8*NB-1:0] dout
);
  always_comb begin
    dout = '0;
    for (int k = 0; k < NB; k++) begin
      if (k < (1 << size_code)) dout[8*k +: 8] = din[8*k +: 8];
    end
  end
endmodule

// File: rtl/elw_lane_place.sv
module elw_lane_place #(
  parameter int NB = 8,
  parameter int CW = 2,
  parameter int LW = 7,
  parameter int RW = 5
) (
  input  logic [LW-1:0]   elem_idx,
  input  logic [CW-1:0]   size_code,
  input  logic [RW-1:0]   reg_base,
  input  logic [8*NB-1:0] value,
  output logic [RW-1:0]   reg_addr,
  output logic [8*NB-1:0] wdata,
  output logic [NB-1:0]   be
);
  localparam int OFFW = $clog2(NB);
  localparam int SHW  = LW + (1 << CW);

  logic [SHW-1:0]  byte_pos;
  logic [OFFW-1:0] off;

  assign byte_pos = SHW'(elem_idx) << size_code;
  assign off      = byte_pos[OFFW-1:0];
  assign reg_addr = reg_base + RW'(byte_pos >> OFFW);
  assign wdata    = value << {off, 3'b000};

  always_comb begin
    for (int b = 0; b < NB; b++)
      be[b] = (b >= int'(off)) && (b < int'(off) + (1 << size_code));
  end
endmodule

// File: rtl/elw_load_seq.sv
module elw_load_seq #(
  parameter int XLEN = 64,
  parameter int AW   = 32,
  parameter int LW   = 7,
  parameter int RW   = 5,
  parameter int CW   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     base_addr,
  input  logic [AW-1:0]     imm_off,
  input  logic [LW-1:0]     vec_len,
  input  logic [CW-1:0]     src_code,
  input  logic [CW-1:0]     dst_code,
  input  logic              le_mode,
  input  logic              rev_flag,
  input  logic [RW-1:0]     dest_reg,
  output logic              busy,
  output logic              done,
  output logic              mem_req_valid,
  output logic [AW-1:0]     mem_req_addr,
  output logic [CW-1:0]     mem_req_size,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              rf_we,
  output logic [RW-1:0]     rf_addr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic [XLEN/8-1:0] rf_be
);
  import elw_pkg::*;
  localparam int NB = XLEN / 8;

  seq_state_t    state;
  logic [LW-1:0] idx, vl_q;
  logic [CW-1:0] dc_q;
  logic [RW-1:0] rd_q;
  logic          swap_q;
  logic [AW-1:0] sbytes;

  logic [XLEN-1:0] ordered, trunc, pl_data;
  logic [RW-1:0]   pl_addr;
  logic [NB-1:0]   pl_be;

  assign busy   = (state == S_WAIT);
  assign sbytes = AW'(1) << mem_req_size;

  elw_byte_order #(.NB(NB), .CW(CW)) u_order (
    .raw(mem_rsp_data), .size_code(mem_req_size), .swap_en(swap_q), .ordered(ordered));

  elw_truncate #(.NB(NB), .CW(CW)) u_trunc (
    .din(ordered), .size_code(dc_q), .dout(trunc));

  elw_lane_place #(.NB(NB), .CW(CW), .LW(LW), .RW(RW)) u_place (
    .elem_idx(idx), .size_code(dc_q), .reg_base(rd_q), .value(trunc),
    .reg_addr(pl_addr), .wdata(pl_data), .be(pl_be));

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      idx           <= '0;
      vl_q          <= '0;
      dc_q          <= '0;
      rd_q          <= '0;
      swap_q        <= 1'b0;
      done          <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_size  <= '0;
      rf_we         <= 1'b0;
      rf_addr       <= '0;
      rf_wdata      <= '0;
      rf_be         <= '0;
    end else begin
      mem_req_valid <= 1'b0;
      rf_we         <= 1'b0;
      done          <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            vl_q         <= vec_len;
            dc_q         <= dst_code;
            rd_q         <= dest_reg;
            swap_q       <= ~(rev_flag ^ le_mode);
            mem_req_size <= src_code;
            idx          <= '0;
            if (vec_len == '0) begin
              done <= 1'b1;
            end else begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= base_addr + imm_off;
              state         <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            rf_we    <= 1'b1;
            rf_addr  <= pl_addr;
            rf_wdata <= pl_data;
            rf_be    <= pl_be;
            idx      <= idx + 1'b1;
            if ({1'b0, idx} + 1'b1 == {1'b0, vl_q}) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= mem_req_addr + sbytes;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [AW-1:0] last_req_addr;
  always_ff @(posedge clk) begin
    if (rst) last_req_addr <= '0;
    else if (mem_req_valid) last_req_addr <= mem_req_addr;
  end

  AST_BE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> ($countones(rf_be) == (32'd1 << dc_q))); // R1

  AST_ADDR_STRIDE: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && rf_we) |-> (mem_req_addr == last_req_addr + sbytes)); // R3

  AST_VL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && start && vec_len == '0) |=> (done && !mem_req_valid)); // R7

  AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && !mem_rsp_valid) |=> !mem_req_valid); // R8

  AST_RSP_WRITE: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && mem_rsp_valid) |=> rf_we); // R9
endmodule

// File: tb/tb_elw_load_seq.sv
`timescale 1ns/1ps
module tb_elw_load_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0, imm_off = '0;
  logic [6:0]  vec_len = '0;
  logic [1:0]  src_code = '0, dst_code = '0;
  logic        le_mode = 1'b0, rev_flag = 1'b0;
  logic [4:0]  dest_reg = '0;
  logic        busy, done, mem_req_valid, rf_we;
  logic [31:0] mem_req_addr;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic [4:0]  rf_addr;
  logic [63:0] rf_wdata;
  logic [7:0]  rf_be;

  always #5 clk = ~clk;

  elw_load_seq dut (.*);

  int checks = 0, errors = 0;
  int req_idx = 0, wr_idx = 0;
  bit pending = 0;

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return 8'((a * 37) + (a >> 8) + 11);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model, R11: byte k of the response holds address+k
  initial begin
    int lat = 0;
    logic [31:0] a = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pending) begin
        if (lat == 0) begin
          for (int k = 0; k < 8; k++) mem_rsp_data[8*k +: 8] = mbyte(a + 32'(k));
          mem_rsp_valid = 1'b1;
          pending = 0;
        end else lat--;
      end
      if (mem_req_valid && !rst) begin
        chk(!pending, "R8 second request while one outstanding", 64'(pending), 64'd0);
        pending = 1;
        a = mem_req_addr;
        lat = req_idx % 3;
      end
    end
  end

  // Monitor: requests and register writes
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && mem_req_valid) begin
        logic [31:0] ea;
        ea = base_addr + imm_off + 32'(req_idx) * (32'd1 << src_code);
        chk(mem_req_addr == ea, "R3 request address", 64'(mem_req_addr), 64'(ea));
        chk(mem_req_size == src_code, "R10 request size code", 64'(mem_req_size), 64'(src_code));
        req_idx++;
      end
      if (!rst && rf_we) begin
        int sw, dw, pos, off;
        bit sw_en;
        logic [31:0] ea;
        logic [63:0] ed;
        logic [7:0]  eb;
        logic [4:0]  er;
        sw = 1 << src_code; dw = 1 << dst_code;
        sw_en = ~(rev_flag ^ le_mode); // R4
        ea = base_addr + imm_off + 32'(wr_idx * sw);
        pos = wr_idx * dw; off = pos % 8;
        er = dest_reg + 5'(pos / 8);
        ed = '0; eb = '0;
        for (int k = 0; k < dw; k++) begin
          eb[off + k] = 1'b1;
          // R2 byte k of element at lane off+k; R5 reverse before truncate; R6 zero above sw
          if (k < sw) ed[8*(off+k) +: 8] = sw_en ? mbyte(ea + 32'(sw - 1 - k)) : mbyte(ea + 32'(k));
        end
        chk(rf_addr == er, "R1 register number", 64'(rf_addr), 64'(er));
        chk(rf_be == eb, "R1 byte enables", 64'(rf_be), 64'(eb));
        for (int b = 0; b < 8; b++) if (!eb[b]) ed[8*b +: 8] = rf_wdata[8*b +: 8];
        chk(rf_wdata == ed, sw_en ? "R5 R6 swapped element data" : "R4 R6 element data", rf_wdata, ed);
        wr_idx++;
      end
    end
  end

  task automatic run(input int sc, input int dc, input bit le, input bit rv, input int vl, input int n);
    int wait_c;
    @(negedge clk);
    src_code = 2'(sc); dst_code = 2'(dc); le_mode = le; rev_flag = rv;
    vec_len = 7'(vl); base_addr = 32'(n * 97 + 5); imm_off = 32'(n % 17);
    dest_reg = 5'(n % 20);
    req_idx = 0; wr_idx = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (vl == 0) begin
      chk(done && req_idx == 0, "R7 zero length completes at once", {done, 32'(req_idx)}, 64'd1 << 32);
      @(negedge clk);
      chk(!busy && !done, "R7 idle after zero length", {busy, done}, 64'd0);
    end else begin
      wait_c = 0;
      while (!done && wait_c < 200) begin @(negedge clk); wait_c++; end
      chk(done && rf_we && wr_idx == vl, "R9 done with last write", 64'(wr_idx), 64'(vl));
      @(negedge clk);
      chk(!done && !busy && req_idx == vl, "R9 single done pulse", {done, busy, 32'(req_idx)}, 64'(vl));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n = 0;
    int vls[4] = '{0, 1, 4, 9};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_req_valid && !rf_we, "R9 reset state",
        {busy, done, mem_req_valid, rf_we}, 64'd0);
    for (int sc = 0; sc < 4; sc++)
      for (int dc = 0; dc < 4; dc++)
        for (int m = 0; m < 4; m++)
          for (int v = 0; v < 4; v++) begin
            run(sc, dc, m[0], m[1], vls[v], n);
            n++;
          end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule